// File: doc/BRIEF.md
# Droop-Triggered Clock Phase Stretcher

This controller lengthens clock cycles while the supply sags. A digitized supply reading is compared against a programmable threshold every cycle. As long as the reading stays at or above that threshold, the phase-select output points at a programmable nominal tap of a multi-phase delay line, and the system clock runs at its full rate. Once the reading falls below the threshold, the controller advances the selected tap by one position per cycle. Each cycle then ends one phase step later than the cycle before it. The advance stops at a programmable maximum offset.

A separate release level, equal to the threshold plus a programmable hysteresis, ends the droop condition. After release, the controller keeps the reached offset for a programmable number of cycles and then returns to the nominal tap. The selection only moves on registered boundaries, and during a stretch it never moves backward, so the downstream clock mux never sees a shortened cycle in the middle of a droop. Pulling the enable low returns the selection to nominal at once. The delay line and the voltage sensor sit outside the block; the phases are modelled as a tap index.

Top module: `droop_phase_stretcher`

## Requirements
- R1: While reset is asserted, `phase_sel` is 0 and `stretch_active` is 0.
- R2: If `vcode` is greater than or equal to `threshold` and no droop is in progress, `phase_sel` stays equal to `base_phase` and `stretch_active` stays 0.
- R3: When `vcode` < `threshold` is sampled at a clock edge, `stretch_active` becomes 1 and `phase_sel` becomes `base_phase`+1 at the third edge counted from that one. With `max_steps` = 0, `stretch_active` still becomes 1 but `phase_sel` stays at `base_phase`.
- R4: While the droop persists, `phase_sel` advances by exactly one tap per cycle. The offset from `base_phase` saturates at `max_steps`.
- R5: A droop ends only when `vcode` >= `threshold` + `hysteresis`, with the sum saturated to the largest code. A reading between the threshold and that level keeps the current stretch.
- R6: After release with `hold_cycles` = H > 0, the reached offset is held, and `stretch_active` remains 1, for H+2 edges after the releasing sample. At the next edge `phase_sel` returns to `base_phase` and `stretch_active` returns to 0.
- R7: With `hold_cycles` = 0, `phase_sel` returns to `base_phase` and `stretch_active` clears at the third edge after the releasing sample.
- R8: A new droop sampled during the hold period resumes stretching from the held offset, without a return to nominal in between.
- R9: When `enable` is 0 at an edge, `phase_sel` equals `base_phase` and `stretch_active` is 0 after that edge, and both stay that way while `enable` remains 0.
- R10: `phase_sel` equals (`base_phase` + offset) modulo `PHASE_N`, wrapping past the last tap.
- R11: While `stretch_active` is 1 in two consecutive cycles, `phase_sel` either stays the same or advances by one tap (modulo `PHASE_N`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Adaptation enable; 0 forces the nominal tap |
| vcode | input | CODE_W | Digitized supply reading |
| threshold | input | CODE_W | Droop entry level |
| hysteresis | input | CODE_W | Release margin above the threshold |
| max_steps | input | PHASE_W | Largest tap offset from nominal |
| hold_cycles | input | HOLD_W | Cycles the offset is held after release |
| base_phase | input | PHASE_W | Nominal tap index |
| phase_sel | output | PHASE_W | Selected delay-line tap |
| stretch_active | output | 1 | High while a stretch or hold is in progress |

## Verification
A corrupted offset counter shows up on `phase_sel` as a jump of more than one tap, or as a wrong saturation value, two edges after the fault. A stuck droop flag or a wrong release comparison keeps `stretch_active` high when the reading has recovered, or drops it inside the hysteresis band, within three edges. A hold counter with the wrong length moves the return to `base_phase` off its expected edge. The directed cases sample the outputs at exact edge counts, so an error of a single cycle is visible.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [1:0] {
    ST_NOMINAL = 2'd0,
    ST_STRETCH = 2'd1,
    ST_HOLD    = 2'd2
  } stretch_state_e;
endpackage

// File: rtl/dps_droop_detect.sv
module dps_droop_detect #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] vcode,
  input  logic [CODE_W-1:0] threshold,
  input  logic [CODE_W-1:0] hysteresis,
  output logic              droop
);
  localparam int SUM_W = CODE_W + 1;

  logic [SUM_W-1:0]  rel_sum;
  logic [CODE_W-1:0] rel_lvl;
  logic              below, above_rel;
  logic              droop_d, droop_q;

  always_comb begin
    rel_sum   = {1'b0, threshold} + {1'b0, hysteresis};
    rel_lvl   = rel_sum[CODE_W] ? {CODE_W{1'b1}} : rel_sum[CODE_W-1:0];
    below     = (vcode < threshold);
    above_rel = (vcode >= rel_lvl);
    droop_d   = droop_q;
    if (!enable)        droop_d = 1'b0;
    else if (below)     droop_d = 1'b1;
    else if (above_rel) droop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) droop_q <= 1'b0;
    else        droop_q <= droop_d;
  end

  assign droop = droop_q;

  // R3: droop is only raised by a reading under the threshold
  assert_entry_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(droop_q) |-> $past(enable && (vcode < threshold)));

  // R5: droop only clears on disable or at the release level
  assert_release_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(droop_q) |-> $past(!enable ||
      ({1'b0, vcode} >= ({1'b0, threshold} + {1'b0, hysteresis})) ||
      (vcode == {CODE_W{1'b1}})));
endmodule

// File: rtl/dps_stretch_fsm.sv
module dps_stretch_fsm
  import dps_pkg::*;
#(
  parameter int PHASE_W = 4,
  parameter int HOLD_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               droop,
  input  logic [PHASE_W-1:0] max_steps,
  input  logic [HOLD_W-1:0]  hold_cycles,
  output logic [PHASE_W-1:0] offset,
  output logic               active
);
  stretch_state_e     state_q, state_d;
  logic [PHASE_W-1:0] off_q, off_d;
  logic [HOLD_W-1:0]  cnt_q, cnt_d;
  logic               cnt_en;
  logic               hold_done;

  always_comb begin
    hold_done = (cnt_q == hold_cycles - HOLD_W'(1));
    state_d   = state_q;
    off_d     = off_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    if (!enable) begin
      state_d = ST_NOMINAL;
      off_d   = '0;
    end else begin
      unique case (state_q)
        ST_NOMINAL: begin
          if (droop) begin
            state_d = ST_STRETCH;
            off_d   = (max_steps != '0) ? PHASE_W'(1) : '0;
          end
        end
        ST_STRETCH: begin
          if (droop) begin
            if (off_q < max_steps) off_d = off_q + PHASE_W'(1);
          end else if (hold_cycles == '0) begin
            state_d = ST_NOMINAL;
            off_d   = '0;
          end else begin
            state_d = ST_HOLD;
            cnt_d   = '0;
            cnt_en  = 1'b1;
          end
        end
        ST_HOLD: begin
          if (droop) begin
            state_d = ST_STRETCH;
          end else if (hold_done) begin
            state_d = ST_NOMINAL;
            off_d   = '0;
          end else begin
            cnt_d  = cnt_q + HOLD_W'(1);
            cnt_en = 1'b1;
          end
        end
        default: begin
          state_d = ST_NOMINAL;
          off_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NOMINAL;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign offset = off_q;
  assign active = (state_q != ST_NOMINAL);

  // R9: disable returns the controller to nominal after one edge
  assert_enable_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (off_q == '0) && (state_q == ST_NOMINAL));

  // R4: the offset only grows by one step, and only on a droop
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != $past(off_q)) && (off_q != '0) |->
      (off_q == $past(off_q) + PHASE_W'(1)) && $past(droop));

  // R6: hold exits to nominal only after the programmed count
  assert_hold_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_HOLD) && (state_q == ST_NOMINAL) && $past(enable) |->
      ($past(cnt_q) == $past(hold_cycles) - HOLD_W'(1)));
endmodule

// File: rtl/dps_phase_out.sv
module dps_phase_out #(
  parameter int PHASE_N = 16,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [PHASE_W-1:0] base_phase,
  input  logic [PHASE_W-1:0] offset,
  input  logic               active_in,
  output logic [PHASE_W-1:0] phase_sel,
  output logic               stretch_active
);
  localparam int SUM_W = PHASE_W + 1;
  localparam logic [SUM_W-1:0] N_EXT = SUM_W'(PHASE_N);

  logic [SUM_W-1:0]   sum;
  logic [PHASE_W-1:0] sel_d, sel_q;
  logic               act_d, act_q;
  logic               load_en;

  always_comb begin
    sum = {1'b0, base_phase} + {1'b0, offset};
    if (sum >= N_EXT) sum = sum - N_EXT;
    if (!enable) begin
      sel_d = base_phase;
      act_d = 1'b0;
    end else begin
      sel_d = sum[PHASE_W-1:0];
      act_d = active_in;
    end
    load_en = (sel_d != sel_q) || (act_d != act_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      act_q <= 1'b0;
    end else if (load_en) begin
      sel_q <= sel_d;
      act_q <= act_d;
    end
  end

  assign phase_sel      = sel_q;
  assign stretch_active = act_q;

  // R11: during a stretch the tap never moves back or skips
  assert_no_runt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && $past(act_q) |->
      (sel_q == $past(sel_q)) ||
      ({1'b0, sel_q} == (({1'b0, $past(sel_q)} + SUM_W'(1)) % N_EXT)));

  // R9: no stretch flag after a disabled edge
  assert_flag_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !act_q && (sel_q == $past(base_phase)));
endmodule

// File: rtl/droop_phase_stretcher.sv
module droop_phase_stretcher #(
  parameter int CODE_W  = 8,
  parameter int PHASE_N = 16,
  parameter int HOLD_W  = 8,
  localparam int PHASE_W = (PHASE_N > 1) ? $clog2(PHASE_N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [CODE_W-1:0]  vcode,
  input  logic [CODE_W-1:0]  threshold,
  input  logic [CODE_W-1:0]  hysteresis,
  input  logic [PHASE_W-1:0] max_steps,
  input  logic [HOLD_W-1:0]  hold_cycles,
  input  logic [PHASE_W-1:0] base_phase,
  output logic [PHASE_W-1:0] phase_sel,
  output logic               stretch_active
);
  logic               droop;
  logic [PHASE_W-1:0] offset;
  logic               fsm_active;

  dps_droop_detect #(.CODE_W(CODE_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .enable(enable), .vcode(vcode),
    .threshold(threshold), .hysteresis(hysteresis), .droop(droop)
  );

  dps_stretch_fsm #(.PHASE_W(PHASE_W), .HOLD_W(HOLD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .droop(droop),
    .max_steps(max_steps), .hold_cycles(hold_cycles),
    .offset(offset), .active(fsm_active)
  );

  dps_phase_out #(.PHASE_N(PHASE_N), .PHASE_W(PHASE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_phase(base_phase),
    .offset(offset), .active_in(fsm_active),
    .phase_sel(phase_sel), .stretch_active(stretch_active)
  );

  // R10: selected tap always lies inside the delay line
  assert_tap_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase_sel) < PHASE_N);
endmodule

// File: tb/droop_phase_stretcher_bench.sv
module droop_phase_stretcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 8;
  localparam int PHASE_N = 16;
  localparam int HOLD_W = 8;
  localparam int PHASE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [CODE_W-1:0]  vcode = 8'd200;
  logic [CODE_W-1:0]  threshold = 8'd100;
  logic [CODE_W-1:0]  hysteresis = 8'd10;
  logic [PHASE_W-1:0] max_steps = 4'd5;
  logic [HOLD_W-1:0]  hold_cycles = 8'd3;
  logic [PHASE_W-1:0] base_phase = 4'd2;
  logic [PHASE_W-1:0] phase_sel;
  logic               stretch_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  droop_phase_stretcher u_droop_phase_stretcher (
    .clk(clk), .rst_n(rst_n), .enable(enable), .vcode(vcode),
    .threshold(threshold), .hysteresis(hysteresis), .max_steps(max_steps),
    .hold_cycles(hold_cycles), .base_phase(base_phase),
    .phase_sel(phase_sel), .stretch_active(stretch_active)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int exp_ph, input bit exp_act);
    checks++;
    if (phase_sel !== PHASE_W'(exp_ph) || stretch_active !== exp_act) begin
      fails++;
      $display("FAIL %s: phase_sel=%0d stretch_active=%0b expected phase_sel=%0d stretch_active=%0b",
               req, phase_sel, stretch_active, exp_ph, exp_act);
    end
  endtask

  task automatic t_reset();
    step(2);
    check("R1 reset", 0, 0);
    rst_n = 1'b1;
    enable = 1'b1;
    step(3);
    check("R2 nominal after reset", 2, 0);
  endtask

  task automatic t_no_adapt();
    vcode = 8'd100;
    step(5);
    check("R2 reading at threshold", 2, 0);
    vcode = 8'd101;
    step(3);
    check("R2 reading above threshold", 2, 0);
  endtask

  task automatic t_droop_and_release();
    vcode = 8'd90;
    step(2);
    check("R3 before third edge", 2, 0);
    step(1);
    check("R3 entry", 3, 1);
    step(1);
    check("R4 one step per cycle", 4, 1);
    step(6);
    check("R4 saturate at max_steps", 7, 1);
    vcode = 8'd105;
    step(6);
    check("R5 inside hysteresis band", 7, 1);
    vcode = 8'd120;
    step(5);
    check("R6 offset held", 7, 1);
    step(1);
    check("R6 return to nominal", 2, 0);
  endtask

  task automatic t_redroop_in_hold();
    vcode = 8'd90;
    step(10);
    check("R8 stretch reached", 7, 1);
    vcode = 8'd120;
    step(3);
    vcode = 8'd90;
    step(1);
    check("R8 still holding", 7, 1);
    step(5);
    check("R8 resumed without nominal", 7, 1);
  endtask

  task automatic t_hold_zero();
    hold_cycles = 8'd0;
    vcode = 8'd120;
    step(2);
    check("R7 before return", 7, 1);
    step(1);
    check("R7 immediate return", 2, 0);
    hold_cycles = 8'd3;
  endtask

  task automatic t_enable_off();
    vcode = 8'd90;
    step(5);
    check("R9 stretching before disable", 5, 1);
    enable = 1'b0;
    step(1);
    check("R9 forced nominal", 2, 0);
    step(3);
    check("R9 stays nominal", 2, 0);
    vcode = 8'd120;
    enable = 1'b1;
    step(4);
    check("R9 re-enabled nominal", 2, 0);
  endtask

  task automatic t_wrap();
    base_phase = 4'd14;
    step(2);
    check("R10 new base", 14, 0);
    vcode = 8'd90;
    step(3);
    check("R10 last tap", 15, 1);
    step(1);
    check("R10 wrap to tap 0", 0, 1);
    step(6);
    check("R10 wrapped saturation", 3, 1);
    hold_cycles = 8'd0;
    vcode = 8'd120;
    step(3);
    check("R10 back to base", 14, 0);
    hold_cycles = 8'd3;
    base_phase = 4'd2;
    step(2);
  endtask

  task automatic t_max_zero();
    max_steps = 4'd0;
    step(1);
    vcode = 8'd90;
    step(4);
    check("R3 max_steps zero", 2, 1);
    hold_cycles = 8'd0;
    vcode = 8'd120;
    step(3);
    check("R7 release with max zero", 2, 0);
    max_steps = 4'd5;
    hold_cycles = 8'd3;
  endtask

  task automatic t_hyst_saturate();
    hysteresis = 8'd250;
    vcode = 8'd90;
    step(5);
    check("R5 saturated entry", 5, 1);
    vcode = 8'd254;
    step(5);
    check("R5 below saturated level", 7, 1);
    hold_cycles = 8'd0;
    vcode = 8'd255;
    step(3);
    check("R5 release at largest code", 2, 0);
    hysteresis = 8'd10;
    hold_cycles = 8'd3;
  endtask

  initial begin
    t_reset();
    t_no_adapt();
    t_droop_and_release();
    t_redroop_in_hold();
    t_hold_zero();
    t_enable_off();
    t_wrap();
    t_max_zero();
    t_hyst_saturate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule